// File: doc/BRIEF.md
# Interrupt Controller Command Register Sequencer

This block is the programming front end of one eight-line interrupt controller. A host writes bytes to two addresses. On the command address a byte either restarts the controller, sets control options (read select, poll, special mask), or issues an operational command: an end-of-interrupt, a rotation, or both. On the data address a byte walks through the start-up sequence (vector base, cascade word, optional mode word) and, once that is done, loads the line mask. A separate select input reaches an edge/level control register. Each instance has a fixed mask on that register, so some of its bits cannot be written.

The block holds the pending, in-service and mask registers, the rotation base, the vector base and the mode bits, and drives them to a priority resolver outside the block. That resolver returns two results: the currently winning line and the highest-priority in-service line. The block uses them for priority-based end-of-interrupt and for poll reads. Pending and in-service bits are set by pulse inputs from the trigger and acknowledge logic. Reads return registered data one cycle after the request.

Top module: `irqc_cmd_seq`

## Requirements
- R1: A synchronous reset clears the mask, pending, in-service and edge/level registers, the rotation base, the vector base, all mode bits and the interrupt output.
- R2: A command-address write with data bit 4 set clears the mask, pending and in-service registers, the rotation base, the vector base and all mode bits, and drops the interrupt output. It keeps the edge/level register and starts the start-up sequence.
- R3: The first data-address write after a restart loads the vector base as data AND 0xF8. The second data-address write changes no register. If bit 0 of the restart byte was clear, the block then returns to normal operation.
- R4: If bit 0 of the restart byte was set, a third data-address write sets the nested-mode bit from data bit 4 and the auto-EOI bit from data bit 1. Later data-address writes load the mask.
- R5: A command write with bit 3 set and bit 4 clear is a control word. When bit 1 is set, bit 0 picks the source for command-address reads: 1 gives in-service, 0 gives pending. When bit 6 is set, bit 5 loads the special-mask bit. Clear enable bits leave their targets unchanged. A data-address read returns the mask.
- R6: Operational codes (data bits 7:5) 0 and 4 load the rotate-on-auto-EOI bit from bit 7.
- R7: Code 1 clears the in-service bit of the reported highest in-service line. Code 5 does the same and also sets the rotation base to that line plus 1 (mod 8). Neither code has any effect when no in-service line is reported.
- R8: Code 3 clears the in-service bit named by bits 2:0. Code 7 clears that bit and sets the rotation base to that line plus 1. Code 6 sets the rotation base to bits 2:0 plus 1 (mod 8). Code 2 changes nothing.
- R9: Control bit 2 arms poll. The next register read returns the winning line number and clears that line's pending and in-service bits, or returns 7 when no line wins. It then disarms poll.
- R10: An edge/level write stores data AND a per-instance keep mask (0xF8 for a master, 0xDE for a slave), and an edge/level read returns the stored value.
- R11: The interrupt output is a registered copy of the resolver's win flag while the block is in normal operation. It is held low during the start-up sequence.
- R12: Read data and its valid flag appear in the cycle after the read request, and the flag is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 1 | 0 = command address, 1 = data address |
| elr_sel | input | 1 | Access goes to the edge/level register |
| wdata | input | 8 | Write byte |
| req_set | input | 8 | Pulses that set pending bits |
| ack_set | input | 8 | Pulses that set in-service bits |
| win_valid | input | 1 | Resolver reports a winning line |
| win_line | input | 3 | Winning line number |
| isr_top_valid | input | 1 | Some line is in service |
| isr_top_line | input | 3 | Highest-priority in-service line |
| rdata | output | 8 | Read byte |
| rd_valid | output | 1 | Read byte valid |
| irq_out | output | 1 | Interrupt request to the processor |
| mask_o | output | 8 | Line mask |
| irr_o | output | 8 | Pending register |
| isr_o | output | 8 | In-service register |
| elcr_o | output | 8 | Edge/level register |
| rot_base | output | 3 | Rotation base for the resolver |
| vec_base | output | 8 | Vector base |
| nested_o | output | 1 | Special fully nested mode |
| aeoi_o | output | 1 | Auto end-of-interrupt |
| rot_aeoi_o | output | 1 | Rotate on auto end-of-interrupt |
| smask_o | output | 1 | Special mask mode |

## Verification
The start-up sequence is driven two ways, once with the mode word and once without, so that a missing or extra step shows up as a wrong mask after the sequence. The eight operational codes are each applied to in-service patterns with several bits set. In each case the surviving bits and the rotation base tell a priority-based clear from a clear by line number, and tell a rotating command from a non-rotating one. Poll reads are made with a winner and without one, and the read that follows is checked to confirm that the poll was disarmed. Control words with the enable bits clear confirm that read select and special mask keep their values.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_VEC  = 2'd1,
    ST_CASC = 2'd2,
    ST_MODE = 2'd3
  } init_st_t;

  typedef enum logic [2:0] {
    OP_RAEOI0 = 3'd0,
    OP_EOI    = 3'd1,
    OP_NOP    = 3'd2,
    OP_SEOI   = 3'd3,
    OP_RAEOI1 = 3'd4,
    OP_REOI   = 3'd5,
    OP_SETPRI = 3'd6,
    OP_RSEOI  = 3'd7
  } op_code_t;
endpackage

// File: rtl/irqc_init_fsm.sv
module irqc_init_fsm
  import irqc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  input  logic     want4,
  input  logic     dwr,
  output init_st_t st,
  output logic     ld_vec,
  output logic     ld_mode,
  output logic     ld_mask
);
  init_st_t st_q;
  logic     want4_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_RUN;
      want4_q <= 1'b0;
    end else if (start) begin
      st_q    <= ST_VEC;
      want4_q <= want4;
    end else if (dwr) begin
      case (st_q)
        ST_VEC:  st_q <= ST_CASC;
        ST_CASC: st_q <= want4_q ? ST_MODE : ST_RUN;
        ST_MODE: st_q <= ST_RUN;
        default: st_q <= ST_RUN;
      endcase
    end
  end

  assign st      = st_q;
  assign ld_vec  = dwr && (st_q == ST_VEC);
  assign ld_mode = dwr && (st_q == ST_MODE);
  assign ld_mask = dwr && (st_q == ST_RUN);
endmodule

// File: rtl/irqc_cmd_dec.sv
module irqc_cmd_dec
  import irqc_pkg::*;
#(
  parameter int N_LINES = 8,
  localparam int LW = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] wdata,
  input  logic               top_valid,
  input  logic [LW-1:0]      top_line,
  output logic [N_LINES-1:0] isr_clr,
  output logic               rot_we,
  output logic [LW-1:0]      rot_val,
  output logic               raeoi_we
);
  op_code_t      op;
  logic [LW-1:0] nline;

  assign op    = op_code_t'(wdata[N_LINES-1 -: 3]);
  assign nline = wdata[LW-1:0];

  always_comb begin
    isr_clr  = '0;
    rot_we   = 1'b0;
    rot_val  = '0;
    raeoi_we = 1'b0;
    case (op)
      OP_RAEOI0, OP_RAEOI1: raeoi_we = 1'b1;
      OP_EOI: if (top_valid) isr_clr = N_LINES'(1) << top_line;
      OP_REOI: if (top_valid) begin
        isr_clr = N_LINES'(1) << top_line;
        rot_we  = 1'b1;
        rot_val = top_line + LW'(1);
      end
      OP_SEOI: isr_clr = N_LINES'(1) << nline;
      OP_SETPRI: begin
        rot_we  = 1'b1;
        rot_val = nline + LW'(1);
      end
      OP_RSEOI: begin
        isr_clr = N_LINES'(1) << nline;
        rot_we  = 1'b1;
        rot_val = nline + LW'(1);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/irqc_cmd_seq.sv
module irqc_cmd_seq
  import irqc_pkg::*;
#(
  parameter int             N_LINES     = 8,
  parameter bit             IS_SLAVE    = 1'b0,
  parameter logic [N_LINES-1:0] MASTER_KEEP = 8'hF8,
  parameter logic [N_LINES-1:0] SLAVE_KEEP  = 8'hDE,
  localparam int            LW          = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic               addr,
  input  logic               elr_sel,
  input  logic [N_LINES-1:0] wdata,
  input  logic [N_LINES-1:0] req_set,
  input  logic [N_LINES-1:0] ack_set,
  input  logic               win_valid,
  input  logic [LW-1:0]      win_line,
  input  logic               isr_top_valid,
  input  logic [LW-1:0]      isr_top_line,
  output logic [N_LINES-1:0] rdata,
  output logic               rd_valid,
  output logic               irq_out,
  output logic [N_LINES-1:0] mask_o,
  output logic [N_LINES-1:0] irr_o,
  output logic [N_LINES-1:0] isr_o,
  output logic [N_LINES-1:0] elcr_o,
  output logic [LW-1:0]      rot_base,
  output logic [N_LINES-1:0] vec_base,
  output logic               nested_o,
  output logic               aeoi_o,
  output logic               rot_aeoi_o,
  output logic               smask_o
);
  localparam logic [N_LINES-1:0] ELR_KEEP = IS_SLAVE ? SLAVE_KEEP : MASTER_KEEP;
  localparam logic [N_LINES-1:0] VEC_KEEP = ~N_LINES'(N_LINES - 1);
  localparam logic [N_LINES-1:0] NONE_WIN = N_LINES'(N_LINES - 1);

  logic [N_LINES-1:0] mask_q, irr_q, isr_q, elcr_q, vec_q, rdata_q;
  logic [LW-1:0]      rot_q;
  logic               nest_q, aeoi_q, raeoi_q, smask_q, rsel_q, poll_q;
  logic               rdv_q, irq_q;

  logic cw, dw, init_go, ctl_go, op_go, poll_rd;
  assign cw      = wr_en && !elr_sel && !addr;
  assign dw      = wr_en && !elr_sel && addr;
  assign init_go = cw && wdata[4];
  assign ctl_go  = cw && !wdata[4] && wdata[3];
  assign op_go   = cw && !wdata[4] && !wdata[3];
  assign poll_rd = rd_en && !elr_sel && poll_q;

  init_st_t st;
  logic     ld_vec, ld_mode, ld_mask;

  irqc_init_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .start   (init_go),
    .want4   (wdata[0]),
    .dwr     (dw),
    .st      (st),
    .ld_vec  (ld_vec),
    .ld_mode (ld_mode),
    .ld_mask (ld_mask)
  );

  logic [N_LINES-1:0] dec_clr;
  logic               dec_rot_we, dec_raeoi_we;
  logic [LW-1:0]      dec_rot_val;

  irqc_cmd_dec #(.N_LINES(N_LINES)) u_dec (
    .wdata     (wdata),
    .top_valid (isr_top_valid),
    .top_line  (isr_top_line),
    .isr_clr   (dec_clr),
    .rot_we    (dec_rot_we),
    .rot_val   (dec_rot_val),
    .raeoi_we  (dec_raeoi_we)
  );

  logic [N_LINES-1:0] op_clr, poll_clr;
  assign op_clr   = op_go ? dec_clr : '0;
  assign poll_clr = (poll_rd && win_valid) ? (N_LINES'(1) << win_line) : '0;

  always_ff @(posedge clk) begin
    if (rst || init_go) begin
      mask_q  <= '0;
      irr_q   <= '0;
      isr_q   <= '0;
      vec_q   <= '0;
      rot_q   <= '0;
      nest_q  <= 1'b0;
      aeoi_q  <= 1'b0;
      raeoi_q <= 1'b0;
      smask_q <= 1'b0;
      rsel_q  <= 1'b0;
      poll_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irr_q <= (irr_q & ~poll_clr) | req_set;
      isr_q <= (isr_q & ~op_clr & ~poll_clr) | ack_set;
      if (ld_mask) mask_q <= wdata;
      if (ld_vec)  vec_q  <= wdata & VEC_KEEP;
      if (ld_mode) begin
        nest_q <= wdata[4];
        aeoi_q <= wdata[1];
      end
      if (ctl_go && wdata[1]) rsel_q  <= wdata[0];
      if (ctl_go && wdata[6]) smask_q <= wdata[5];
      if (op_go && dec_raeoi_we) raeoi_q <= wdata[7];
      if (op_go && dec_rot_we)   rot_q   <= dec_rot_val;
      if (ctl_go && wdata[2]) poll_q <= 1'b1;
      else if (poll_rd)       poll_q <= 1'b0;
      irq_q <= (st == ST_RUN) && win_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      elcr_q  <= '0;
      rdata_q <= '0;
      rdv_q   <= 1'b0;
    end else begin
      if (wr_en && elr_sel) elcr_q <= wdata & ELR_KEEP;
      rdv_q <= rd_en;
      if (rd_en) begin
        if (elr_sel)      rdata_q <= elcr_q;
        else if (poll_q)  rdata_q <= win_valid ? N_LINES'(win_line) : NONE_WIN;
        else if (addr)    rdata_q <= mask_q;
        else if (rsel_q)  rdata_q <= isr_q;
        else              rdata_q <= irr_q;
      end
    end
  end

  assign rdata      = rdata_q;
  assign rd_valid   = rdv_q;
  assign irq_out    = irq_q;
  assign mask_o     = mask_q;
  assign irr_o      = irr_q;
  assign isr_o      = isr_q;
  assign elcr_o     = elcr_q;
  assign rot_base   = rot_q;
  assign vec_base   = vec_q;
  assign nested_o   = nest_q;
  assign aeoi_o     = aeoi_q;
  assign rot_aeoi_o = raeoi_q;
  assign smask_o    = smask_q;
endmodule

// File: rtl/irqc_cmd_seq_chk.sv
module irqc_cmd_seq_chk #(
  parameter int N_LINES = 8,
  localparam int LW = $clog2(N_LINES)
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic               rd_en,
  input logic               addr,
  input logic               elr_sel,
  input logic [N_LINES-1:0] wdata,
  input logic               win_valid,
  input logic [N_LINES-1:0] rdata,
  input logic               rd_valid,
  input logic               irq_out,
  input logic [N_LINES-1:0] mask_o,
  input logic [N_LINES-1:0] isr_o,
  input logic [N_LINES-1:0] elcr_o,
  input logic [LW-1:0]      rot_base,
  input logic               poll_q,
  input logic [N_LINES-1:0] keep
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (mask_o == '0) && !irq_out && (rot_base == '0) && (elcr_o == '0));

  p_init_clears_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !elr_sel && !addr && wdata[4]) |=> (mask_o == '0) && (isr_o == '0) && !irq_out);

  p_quiet_regs_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(rot_base) && $stable(mask_o));

  p_poll_none_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !elr_sel && poll_q && !win_valid) |=> (rdata == N_LINES'(N_LINES - 1)));

  p_elr_write_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && elr_sel) |=> (elcr_o == ($past(wdata) & keep)));

  p_rd_valid_r12: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  p_rd_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
endmodule

bind irqc_cmd_seq irqc_cmd_seq_chk #(.N_LINES(N_LINES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .addr      (addr),
  .elr_sel   (elr_sel),
  .wdata     (wdata),
  .win_valid (win_valid),
  .rdata     (rdata),
  .rd_valid  (rd_valid),
  .irq_out   (irq_out),
  .mask_o    (mask_o),
  .isr_o     (isr_o),
  .elcr_o    (elcr_o),
  .rot_base  (rot_base),
  .poll_q    (poll_q),
  .keep      (ELR_KEEP)
);

// File: tb/test_irqc_cmd_seq.sv
module test_irqc_cmd_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, elr_sel = 1'b0;
  logic [7:0] wdata = '0, req_set = '0, ack_set = '0;
  logic       win_valid = 1'b0, isr_top_valid = 1'b0;
  logic [2:0] win_line = '0, isr_top_line = '0;
  logic [7:0] rdata, mask_o, irr_o, isr_o, elcr_o, vec_base;
  logic       rd_valid, irq_out, nested_o, aeoi_o, rot_aeoi_o, smask_o;
  logic [2:0] rot_base;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  irqc_cmd_seq i_irqc_cmd_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .elr_sel(elr_sel), .wdata(wdata), .req_set(req_set), .ack_set(ack_set),
    .win_valid(win_valid), .win_line(win_line), .isr_top_valid(isr_top_valid),
    .isr_top_line(isr_top_line), .rdata(rdata), .rd_valid(rd_valid),
    .irq_out(irq_out), .mask_o(mask_o), .irr_o(irr_o), .isr_o(isr_o),
    .elcr_o(elcr_o), .rot_base(rot_base), .vec_base(vec_base),
    .nested_o(nested_o), .aeoi_o(aeoi_o), .rot_aeoi_o(rot_aeoi_o),
    .smask_o(smask_o)
  );

  task automatic chk(string r, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(logic a, logic e, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; elr_sel = e; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; elr_sel = 1'b0;
  endtask

  // driver: issue a read and push the expected byte to the scoreboard
  task automatic rd(logic a, logic e, logic [7:0] exp, string r);
    @(negedge clk);
    rd_en = 1'b1; addr = a; elr_sel = e;
    exp_q.push_back(exp);
    tag_q.push_back(r);
    @(negedge clk);
    rd_en = 1'b0; elr_sel = 1'b0;
  endtask

  task automatic pulse_ack(logic [7:0] v);
    @(negedge clk); ack_set = v;
    @(negedge clk); ack_set = '0;
  endtask

  task automatic pulse_req(logic [7:0] v);
    @(negedge clk); req_set = v;
    @(negedge clk); req_set = '0;
  endtask

  // monitor: compare each returned byte against the scoreboard head
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R12: actual=%h expected=<no read pending>", rdata);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string      t = tag_q.pop_front();
        chk(t, rdata, e);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 mask", mask_o, 8'h00);
    chk("R1 irq", {7'b0, irq_out}, 8'h00);
    chk("R1 rot", {5'b0, rot_base}, 8'h00);
    chk("R12 idle", {7'b0, rd_valid}, 8'h00);
    rd(1'b0, 1'b0, 8'h00, "R1 pending read");

    // R10 edge/level keep mask (master instance)
    wr(1'b0, 1'b1, 8'hFF);
    rd(1'b0, 1'b1, 8'hF8, "R10 edge/level read");

    // R4 start-up with mode word; R11 irq held during start-up
    wr(1'b0, 1'b0, 8'h11);
    chk("R2 irq after restart", {7'b0, irq_out}, 8'h00);
    @(negedge clk); win_valid = 1'b1;
    @(negedge clk);
    chk("R11 irq low during start-up", {7'b0, irq_out}, 8'h00);
    win_valid = 1'b0;
    wr(1'b1, 1'b0, 8'h4D);
    chk("R3 vector base", vec_base, 8'h48);
    wr(1'b1, 1'b0, 8'h04);
    chk("R3 cascade word ignored", mask_o, 8'h00);
    wr(1'b1, 1'b0, 8'h12);
    chk("R4 nested", {7'b0, nested_o}, 8'h01);
    chk("R4 auto-eoi", {7'b0, aeoi_o}, 8'h01);
    wr(1'b1, 1'b0, 8'hA5);
    chk("R4 mask after mode word", mask_o, 8'hA5);
    rd(1'b1, 1'b0, 8'hA5, "R5 mask read");

    @(negedge clk); win_valid = 1'b1;
    @(negedge clk);
    chk("R11 irq follows win", {7'b0, irq_out}, 8'h01);
    win_valid = 1'b0;

    // R5 read select
    pulse_req(8'h0C);
    rd(1'b0, 1'b0, 8'h0C, "R5 pending read");
    wr(1'b0, 1'b0, 8'h0B);
    pulse_ack(8'h81);
    rd(1'b0, 1'b0, 8'h81, "R5 in-service read");
    wr(1'b0, 1'b0, 8'h0A);
    rd(1'b0, 1'b0, 8'h0C, "R5 select pending");
    wr(1'b0, 1'b0, 8'h0B);
    wr(1'b0, 1'b0, 8'h08);
    rd(1'b0, 1'b0, 8'h81, "R5 select unchanged without enable");
    wr(1'b0, 1'b0, 8'h68);
    chk("R5 special mask set", {7'b0, smask_o}, 8'h01);
    wr(1'b0, 1'b0, 8'h08);
    chk("R5 special mask kept", {7'b0, smask_o}, 8'h01);
    wr(1'b0, 1'b0, 8'h48);
    chk("R5 special mask clear", {7'b0, smask_o}, 8'h00);

    // R6 rotate on auto-eoi
    wr(1'b0, 1'b0, 8'h80);
    chk("R6 code4", {7'b0, rot_aeoi_o}, 8'h01);
    wr(1'b0, 1'b0, 8'h00);
    chk("R6 code0", {7'b0, rot_aeoi_o}, 8'h00);

    // R7 priority-based end-of-interrupt
    @(negedge clk); isr_top_valid = 1'b1; isr_top_line = 3'd7;
    wr(1'b0, 1'b0, 8'h20);
    rd(1'b0, 1'b0, 8'h01, "R7 code1 clears top");
    chk("R7 code1 keeps rot", {5'b0, rot_base}, 8'h00);
    @(negedge clk); isr_top_line = 3'd0;
    wr(1'b0, 1'b0, 8'hA0);
    chk("R7 code5 clears", isr_o, 8'h00);
    chk("R7 code5 rotates", {5'b0, rot_base}, 8'h01);

    // R8 specific commands
    pulse_ack(8'h30);
    wr(1'b0, 1'b0, 8'h64);
    chk("R8 code3 clear", isr_o, 8'h20);
    chk("R8 code3 no rot", {5'b0, rot_base}, 8'h01);
    wr(1'b0, 1'b0, 8'hC5);
    chk("R8 code6 rot", {5'b0, rot_base}, 8'h06);
    wr(1'b0, 1'b0, 8'hE7);
    chk("R8 code7 keeps other line", isr_o, 8'h20);
    chk("R8 code7 rot wraps", {5'b0, rot_base}, 8'h00);
    wr(1'b0, 1'b0, 8'hE5);
    chk("R8 code7 clear", isr_o, 8'h00);
    chk("R8 code7 rot", {5'b0, rot_base}, 8'h06);
    pulse_ack(8'h02);
    wr(1'b0, 1'b0, 8'h41);
    rd(1'b0, 1'b0, 8'h02, "R8 code2 no effect");
    chk("R8 code2 rot", {5'b0, rot_base}, 8'h06);
    @(negedge clk); isr_top_valid = 1'b0; isr_top_line = 3'd1;
    wr(1'b0, 1'b0, 8'h20);
    rd(1'b0, 1'b0, 8'h02, "R7 code1 without top");

    // R9 poll
    @(negedge clk); win_valid = 1'b1; win_line = 3'd3;
    wr(1'b0, 1'b0, 8'h0C);
    rd(1'b0, 1'b0, 8'h03, "R9 poll winner");
    rd(1'b0, 1'b0, 8'h02, "R9 poll disarmed");
    wr(1'b0, 1'b0, 8'h0A);
    rd(1'b0, 1'b0, 8'h04, "R9 pending bit cleared");
    @(negedge clk); win_valid = 1'b0;
    wr(1'b0, 1'b0, 8'h0C);
    rd(1'b0, 1'b0, 8'h07, "R9 poll none");

    // R2 restart keeps edge/level; R3 short sequence
    wr(1'b0, 1'b0, 8'h10);
    chk("R2 mask cleared", mask_o, 8'h00);
    chk("R2 pending cleared", irr_o, 8'h00);
    chk("R2 rot cleared", {5'b0, rot_base}, 8'h00);
    chk("R2 nested cleared", {7'b0, nested_o}, 8'h00);
    rd(1'b0, 1'b1, 8'hF8, "R2 edge/level kept");
    wr(1'b1, 1'b0, 8'h27);
    chk("R3 vector base", vec_base, 8'h20);
    wr(1'b1, 1'b0, 8'hFF);
    wr(1'b1, 1'b0, 8'h3C);
    rd(1'b1, 1'b0, 8'h3C, "R3 mask after short sequence");
    chk("R3 auto-eoi stays clear", {7'b0, aeoi_o}, 8'h00);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R12: actual=%0d reads outstanding expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule